// File: doc/BRIEF.md
# BCD Calendar Core with Change Flags

This block is the timekeeping heart of a low-power real-time clock. It holds eight calendar fields in two-digit BCD: seconds, minutes, hours, day of month, month, two-digit year, weekday and week number. It advances on an externally supplied once-per-second enable and applies month lengths and leap years. A separate externally supplied 32-per-second enable can take over the pacing when an accelerated test mode is selected.

Software-facing logic around the core uses two operations. A load writes all eight fields at once, for example when the time is set. A snapshot copies the eight fields to a holding register together with eight sticky change flags. Each flag tells whether its field moved since the previous snapshot, so a poller can skip reading fields that did not change. A carry-free test mode bumps every field on its own, which lets each field's wrap logic be exercised without waiting for carries.

Top module: `bcd_cal_core`

## Requirements
- R1: After reset the fields read 00:00:00, day 01, month 01, year 00, weekday 1, week 01, and the snapshot flags are zero. Fields are packed one byte each, two BCD digits per byte: byte 0 seconds, 1 minutes, 2 hours, 3 day, 4 month, 5 year, 6 weekday, 7 week. Flag bit i belongs to field byte i.
- R2: On an advance tick in normal mode, seconds count 00..59 and carry into minutes (00..59), then hours (00..23), then day, month (01..12) and year (00..99, where 99 is followed by 00). With no tick, the fields hold.
- R3: A day rolls to 01 and carries into the month after day 31 in months 1, 3, 5, 7, 8, 10 and 12, after day 30 in months 4, 6, 9 and 11, and in February after day 29 when the year value is a multiple of 4, otherwise after day 28.
- R4: The weekday (1..7, Monday = 1) steps with every day carry, and 7 is followed by 1. The week number steps only when the weekday goes from 7 to 1. From week 52 it goes to 00 if the day being left is December 25, 26 or 27, and to 01 otherwise.
- R5: A field whose byte is not valid BCD or is outside its range is set to its lowest legal value (00, or 01 for day, month and weekday) on its next increment, and produces no carry.
- R6: A snapshot request copies the fields and the accumulated flags as they stood before that clock edge. The result appears on the outputs after the edge, and the accumulator restarts from the changes of that same edge.
- R7: A snapshot flag is set when its field changed at any tick since the last snapshot. In normal mode, a set minutes, hours, day, month or year flag implies the flag of the next lower unit is set, the weekday flag implies the hours flag, and the week flag implies the weekday flag.
- R8: With the fast test select high, the 32-per-second enable paces every advance and the once-per-second enable is ignored. With it low, the reverse holds.
- R9: With the parallel test select high, each advance increments all eight fields by one with no carry between them. Each field wraps to its lowest value after its range top; day wraps after 31, and week 52 goes to 00.
- R10: A load overwrites all eight fields with the load value and clears the change flags. It takes priority over an advance in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| tick_1hz | input | 1 | Once-per-second advance enable |
| tick_32hz | input | 1 | 32-per-second advance enable |
| test_fast | input | 1 | Selects the 32-per-second enable as the pacing source |
| test_par | input | 1 | Selects carry-free parallel increment |
| load_en | input | 1 | Load all fields from load_val |
| load_val | input | 64 | Eight packed BCD fields to load |
| snap_req | input | 1 | Take a snapshot |
| snap_val | output | 64 | Captured eight BCD fields |
| snap_flags | output | 8 | Captured change flags |

## Verification
An advance, load or snapshot request applied in one cycle takes effect at the next rising edge. Snapshot outputs are registered, so a field change made at edge k is visible at the outputs only after a snapshot request in a later cycle has been captured at its edge. The bench therefore drives every input at a falling edge, holds it for one full cycle, issues the snapshot in the following cycle, and compares at the falling edge after that. To check R6 ordering, one case puts the snapshot in the same cycle as a tick and expects the values from before the tick.

// File: rtl/bcd_cal_pkg.sv
package bcd_cal_pkg;
    localparam int FW = 8;
    localparam int NF = 8;
    localparam int TW = FW * NF;

    localparam int F_SEC = 0;
    localparam int F_MIN = 1;
    localparam int F_HR  = 2;
    localparam int F_DAY = 3;
    localparam int F_MON = 4;
    localparam int F_YR  = 5;
    localparam int F_WD  = 6;
    localparam int F_WK  = 7;

    localparam logic [TW-1:0] RESET_TIME = 64'h01_01_00_01_01_00_00_00;

    typedef struct packed {
        logic [TW-1:0] tm;
        logic [NF-1:0] acc;
        logic [TW-1:0] snap;
        logic [NF-1:0] sfl;
    } core_st_t;

    function automatic logic [FW-1:0] bcd2bin(input logic [FW-1:0] v);
        return {4'd0, v[7:4]} * 8'd10 + {4'd0, v[3:0]};
    endfunction

    function automatic logic [FW-1:0] bin2bcd(input logic [FW-1:0] b);
        logic [FW-1:0] tens;
        logic [FW-1:0] ones;
        tens = b / 8'd10;
        ones = b - tens * 8'd10;
        return {tens[3:0], ones[3:0]};
    endfunction

    function automatic logic [FW-1:0] fld_lo(input int i);
        return (i == F_DAY || i == F_MON || i == F_WD) ? 8'd1 : 8'd0;
    endfunction

    function automatic logic [FW-1:0] fld_hi(input int i);
        case (i)
            F_SEC, F_MIN: return 8'd59;
            F_HR:         return 8'd23;
            F_DAY:        return 8'd31;
            F_MON:        return 8'd12;
            F_YR:         return 8'd99;
            F_WD:         return 8'd7;
            default:      return 8'd52;
        endcase
    endfunction
endpackage

// File: rtl/bcd_step.sv
module bcd_step
    import bcd_cal_pkg::*;
(
    input  logic [FW-1:0] cur,
    input  logic [FW-1:0] lo_lim,
    input  logic [FW-1:0] hi_lim,
    input  logic [FW-1:0] wrap_at,
    output logic [FW-1:0] nxt,
    output logic          wrap
);
    logic [FW-1:0] bin;
    logic          legal;

    always_comb begin
        bin   = bcd2bin(cur);
        legal = (cur[7:4] <= 4'd9) && (cur[3:0] <= 4'd9) &&
                (bin >= lo_lim) && (bin <= hi_lim);
        wrap  = 1'b0;
        if (!legal) begin
            nxt = bin2bcd(lo_lim);
        end else if (bin >= wrap_at) begin
            nxt  = bin2bcd(lo_lim);
            wrap = 1'b1;
        end else if (cur[3:0] == 4'd9) begin
            nxt = {cur[7:4] + 4'd1, 4'd0};
        end else begin
            nxt = {cur[7:4], cur[3:0] + 4'd1};
        end
    end
endmodule

// File: rtl/month_len.sv
module month_len
    import bcd_cal_pkg::*;
(
    input  logic [FW-1:0] mon_bcd,
    input  logic [FW-1:0] yr_bcd,
    output logic [FW-1:0] days
);
    logic [FW-1:0] mon_b;
    logic [FW-1:0] yr_b;

    always_comb begin
        mon_b = bcd2bin(mon_bcd);
        yr_b  = bcd2bin(yr_bcd);
        case (mon_b)
            8'd2:                    days = (yr_b[1:0] == 2'b00) ? 8'd29 : 8'd28;
            8'd4, 8'd6, 8'd9, 8'd11: days = 8'd30;
            default:                 days = 8'd31;
        endcase
    end
endmodule

// File: rtl/bcd_cal_core.sv
module bcd_cal_core
    import bcd_cal_pkg::*;
(
    input  logic          clk,
    input  logic          rst_n,
    input  logic          tick_1hz,
    input  logic          tick_32hz,
    input  logic          test_fast,
    input  logic          test_par,
    input  logic          load_en,
    input  logic [TW-1:0] load_val,
    input  logic          snap_req,
    output logic [TW-1:0] snap_val,
    output logic [NF-1:0] snap_flags
);
    core_st_t      st_q, st_d;
    logic [FW-1:0] cur      [NF];
    logic [FW-1:0] wat      [NF];
    logic [FW-1:0] stp_nxt  [NF];
    logic          stp_wrap [NF];
    logic [FW-1:0] mdays;
    logic [TW-1:0] time_q;
    logic [NF-1:0] acc_q;

    assign time_q = st_q.tm;
    assign acc_q  = st_q.acc;

    always_comb begin
        for (int i = 0; i < NF; i++) begin
            cur[i] = st_q.tm[i*FW +: FW];
            wat[i] = fld_hi(i);
        end
        if (!test_par) wat[F_DAY] = mdays;
    end

    month_len u_mlen (
        .mon_bcd (cur[F_MON]),
        .yr_bcd  (cur[F_YR]),
        .days    (mdays)
    );

    for (genvar g = 0; g < NF; g++) begin : g_step
        bcd_step u_step (
            .cur     (cur[g]),
            .lo_lim  (fld_lo(g)),
            .hi_lim  (fld_hi(g)),
            .wrap_at (wat[g]),
            .nxt     (stp_nxt[g]),
            .wrap    (stp_wrap[g])
        );
    end

    logic          adv;
    logic          dec_end;
    logic [FW-1:0] nt  [NF];
    logic [NF-1:0] chg;
    logic          c_min, c_hr, c_day, c_mon, c_yr;

    always_comb begin
        adv     = test_fast ? tick_32hz : tick_1hz;
        dec_end = (cur[F_MON] == 8'h12) && (cur[F_DAY] >= 8'h25) &&
                  (cur[F_DAY] <= 8'h27);
        c_min   = stp_wrap[F_SEC];
        c_hr    = c_min & stp_wrap[F_MIN];
        c_day   = c_hr & stp_wrap[F_HR];
        c_mon   = c_day & stp_wrap[F_DAY];
        c_yr    = c_mon & stp_wrap[F_MON];
        for (int i = 0; i < NF; i++) nt[i] = cur[i];

        if (adv) begin
            if (test_par) begin
                for (int i = 0; i < NF; i++) nt[i] = stp_nxt[i];
            end else begin
                nt[F_SEC] = stp_nxt[F_SEC];
                if (c_min) nt[F_MIN] = stp_nxt[F_MIN];
                if (c_hr)  nt[F_HR]  = stp_nxt[F_HR];
                if (c_day) begin
                    nt[F_DAY] = stp_nxt[F_DAY];
                    nt[F_WD]  = stp_nxt[F_WD];
                    if (stp_wrap[F_WD]) begin
                        if (stp_wrap[F_WK]) nt[F_WK] = dec_end ? 8'h00 : 8'h01;
                        else                nt[F_WK] = stp_nxt[F_WK];
                    end
                end
                if (c_mon) nt[F_MON] = stp_nxt[F_MON];
                if (c_yr)  nt[F_YR]  = stp_nxt[F_YR];
            end
        end

        for (int i = 0; i < NF; i++) chg[i] = (nt[i] != cur[i]);

        st_d = st_q;
        for (int i = 0; i < NF; i++) st_d.tm[i*FW +: FW] = nt[i];
        st_d.acc = st_q.acc | chg;
        if (snap_req) begin
            st_d.snap = st_q.tm;
            st_d.sfl  = st_q.acc;
            st_d.acc  = chg;
        end
        if (load_en) begin
            st_d.tm  = load_val;
            st_d.acc = '0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.tm   <= RESET_TIME;
            st_q.acc  <= '0;
            st_q.snap <= '0;
            st_q.sfl  <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign snap_val   = st_q.snap;
    assign snap_flags = st_q.sfl;
endmodule

// File: rtl/bcd_cal_core_chk.sv
module bcd_cal_core_chk
    import bcd_cal_pkg::*;
(
    input logic          clk,
    input logic          rst_n,
    input logic          tick_1hz,
    input logic          tick_32hz,
    input logic          test_fast,
    input logic          load_en,
    input logic [TW-1:0] load_val,
    input logic          snap_req,
    input logic [TW-1:0] snap_val,
    input logic [NF-1:0] snap_flags,
    input logic [TW-1:0] time_q,
    input logic [NF-1:0] acc_q
);
    logic adv_c;
    assign adv_c = test_fast ? tick_32hz : tick_1hz;

    p_snap_copy_r6: assert property (@(posedge clk) disable iff (!rst_n)
        snap_req |=> (snap_val == $past(time_q)) && (snap_flags == $past(acc_q)));

    p_snap_clear_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (snap_req && !adv_c) |=> (acc_q == '0));

    p_load_r10: assert property (@(posedge clk) disable iff (!rst_n)
        load_en |=> (time_q == $past(load_val)) && (acc_q == '0));

    p_idle_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (!adv_c && !load_en) |=> $stable(time_q));

    p_sec_range_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (adv_c && !load_en) |=> (time_q[3:0] <= 4'd9) && (time_q[7:4] <= 4'd5));

    always_comb begin
        if (rst_n) begin
            p_flag_order_r7: assert (
                (!snap_flags[1] || snap_flags[0]) &&
                (!snap_flags[2] || snap_flags[1]) &&
                (!snap_flags[3] || snap_flags[2]) &&
                (!snap_flags[4] || snap_flags[3]) &&
                (!snap_flags[5] || snap_flags[4]) &&
                (!snap_flags[6] || snap_flags[2]) &&
                (!snap_flags[7] || snap_flags[6]) ||
                (snap_flags == '1));
        end
    end
endmodule

bind bcd_cal_core bcd_cal_core_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .tick_1hz   (tick_1hz),
    .tick_32hz  (tick_32hz),
    .test_fast  (test_fast),
    .load_en    (load_en),
    .load_val   (load_val),
    .snap_req   (snap_req),
    .snap_val   (snap_val),
    .snap_flags (snap_flags),
    .time_q     (time_q),
    .acc_q      (acc_q)
);

// File: tb/tb_bcd_cal_core.sv
`timescale 1ns/1ps
module tb_bcd_cal_core;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        tick_1hz = 1'b0;
    logic        tick_32hz = 1'b0;
    logic        test_fast = 1'b0;
    logic        test_par = 1'b0;
    logic        load_en = 1'b0;
    logic [63:0] load_val = '0;
    logic        snap_req = 1'b0;
    logic [63:0] snap_val;
    logic [7:0]  snap_flags;

    int checks = 0;
    int errors = 0;
    int cyc = 0;
    int m [8];
    logic [7:0] mfl = '0;

    always #2.5 clk = ~clk;

    bcd_cal_core dut (
        .clk(clk), .rst_n(rst_n), .tick_1hz(tick_1hz), .tick_32hz(tick_32hz),
        .test_fast(test_fast), .test_par(test_par), .load_en(load_en),
        .load_val(load_val), .snap_req(snap_req), .snap_val(snap_val),
        .snap_flags(snap_flags)
    );

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc == 199000) begin
            errors = errors + 1;
            $display("FAIL R2 watchdog: actual still running expected finished");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    function automatic logic [7:0] b(input int v);
        return {4'(v / 10), 4'(v % 10)};
    endfunction

    function automatic logic [63:0] mpack();
        return {b(m[7]), b(m[6]), b(m[5]), b(m[4]), b(m[3]), b(m[2]), b(m[1]), b(m[0])};
    endfunction

    function automatic int mlen(input int mo, input int y);
        if (mo == 2) return (y % 4 == 0) ? 29 : 28;
        if (mo == 4 || mo == 6 || mo == 9 || mo == 11) return 30;
        return 31;
    endfunction

    task automatic setm(input int s, mi, h, d, mo, y, wd, wk);
        m[0] = s; m[1] = mi; m[2] = h; m[3] = d;
        m[4] = mo; m[5] = y; m[6] = wd; m[7] = wk;
    endtask

    task automatic mark(input logic [63:0] old);
        logic [63:0] nw;
        nw = mpack();
        for (int i = 0; i < 8; i++)
            if (nw[i*8 +: 8] != old[i*8 +: 8]) mfl[i] = 1'b1;
    endtask

    task automatic m_step();
        logic [63:0] old;
        old = mpack();
        m[0]++;
        if (m[0] == 60) begin
            m[0] = 0; m[1]++;
            if (m[1] == 60) begin
                m[1] = 0; m[2]++;
                if (m[2] == 24) begin
                    m[2] = 0;
                    if (m[6] == 7) begin
                        m[6] = 1;
                        if (m[7] == 52) m[7] = (m[4] == 12 && m[3] >= 25 && m[3] <= 27) ? 0 : 1;
                        else m[7]++;
                    end else m[6]++;
                    m[3]++;
                    if (m[3] > mlen(m[4], m[5])) begin
                        m[3] = 1; m[4]++;
                        if (m[4] == 13) begin
                            m[4] = 1; m[5] = (m[5] + 1) % 100;
                        end
                    end
                end
            end
        end
        mark(old);
    endtask

    task automatic m_par();
        logic [63:0] old;
        old = mpack();
        m[0] = (m[0] + 1) % 60;
        m[1] = (m[1] + 1) % 60;
        m[2] = (m[2] + 1) % 24;
        m[3] = (m[3] == 31) ? 1 : m[3] + 1;
        m[4] = (m[4] == 12) ? 1 : m[4] + 1;
        m[5] = (m[5] + 1) % 100;
        m[6] = (m[6] == 7) ? 1 : m[6] + 1;
        m[7] = (m[7] == 52) ? 0 : m[7] + 1;
        mark(old);
    endtask

    task automatic do_load(input logic [63:0] v);
        load_val = v; load_en = 1'b1;
        @(negedge clk);
        load_en = 1'b0;
        mfl = '0;
    endtask

    task automatic pulse1();
        tick_1hz = 1'b1;
        @(negedge clk);
        tick_1hz = 1'b0;
    endtask

    task automatic pulse32();
        tick_32hz = 1'b1;
        @(negedge clk);
        tick_32hz = 1'b0;
    endtask

    task automatic snap_cmp(input string tag, input logic [63:0] ev, input logic [7:0] ef);
        snap_req = 1'b1;
        @(negedge clk);
        snap_req = 1'b0;
        checks++;
        if (snap_val !== ev || snap_flags !== ef) begin
            errors++;
            $display("FAIL %s: actual %h/%h expected %h/%h", tag, snap_val, snap_flags, ev, ef);
        end
    endtask

    task automatic snap_model(input string tag);
        snap_cmp(tag, mpack(), mfl);
        mfl = '0;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        snap_cmp("R1 reset", 64'h01_01_00_01_01_00_00_00, 8'h00);

        // R10 load clears flags
        setm(56, 34, 12, 15, 6, 21, 3, 24);
        do_load(mpack());
        snap_model("R10 load");

        // R2 single tick; no tick holds
        pulse1(); m_step();
        snap_model("R2 one tick");
        repeat (3) @(negedge clk);
        snap_model("R2 idle hold");

        // R7 sticky flags over two ticks, then cleared
        setm(58, 0, 0, 1, 1, 5, 1, 1);
        do_load(mpack());
        pulse1(); m_step();
        pulse1(); m_step();
        snap_cmp("R7 sticky", mpack(), 8'h03);
        mfl = '0;
        snap_cmp("R6 cleared after snap", mpack(), 8'h00);

        // R4 year end week 52 -> 01, full carry
        setm(59, 59, 23, 31, 12, 99, 7, 52);
        do_load(mpack());
        pulse1(); m_step();
        snap_cmp("R4 year end", 64'h01_01_00_01_01_00_00_00, 8'hFF);
        mfl = '0;

        // R4 December 24..28 with weekday 7 in week 52
        for (int d = 24; d <= 28; d++) begin
            setm(59, 59, 23, d, 12, 10, 7, 52);
            do_load(mpack());
            pulse1(); m_step();
            snap_model("R4 dec week roll");
        end

        // R3 month end for every month, leap and plain year
        for (int y = 3; y <= 4; y++) begin
            for (int mo = 1; mo <= 12; mo++) begin
                setm(59, 59, 23, mlen(mo, y), mo, y, 2, 10);
                do_load(mpack());
                pulse1(); m_step();
                snap_model("R3 month end");
            end
        end
        setm(59, 59, 23, 28, 2, 4, 3, 9);
        do_load(mpack());
        pulse1(); m_step();
        snap_cmp("R3 leap feb 29", 64'h09_04_04_02_29_00_00_00, 8'h4F);
        mfl = '0;

        // R5 out-of-range seconds cleared, no carry
        do_load(64'h05_02_07_03_10_14_20_75);
        pulse1();
        snap_cmp("R5 bad seconds", 64'h05_02_07_03_10_14_20_00, 8'h01);
        // R5 out-of-range day cleared to 01, no month carry
        do_load(64'h05_03_07_03_32_23_59_59);
        pulse1();
        snap_cmp("R5 bad day", 64'h05_04_07_03_01_00_00_00, 8'h4F);
        do_load(64'h05_03_07_03_10_14_20_3A);
        pulse1();
        snap_cmp("R5 bad bcd digit", 64'h05_03_07_03_10_14_20_00, 8'h01);

        // R6 snapshot in same cycle as a tick sees pre-tick state
        setm(10, 0, 0, 1, 1, 1, 1, 1);
        do_load(mpack());
        tick_1hz = 1'b1; snap_req = 1'b1;
        @(negedge clk);
        tick_1hz = 1'b0; snap_req = 1'b0;
        checks++;
        if (snap_val !== mpack() || snap_flags !== 8'h00) begin
            errors++;
            $display("FAIL R6 same-cycle: actual %h/%h expected %h/00", snap_val, snap_flags, mpack());
        end
        m_step();
        snap_model("R6 post tick");

        // R10 load beats tick in same cycle
        setm(30, 30, 10, 10, 10, 10, 5, 40);
        tick_1hz = 1'b1;
        do_load(mpack());
        tick_1hz = 1'b0;
        snap_model("R10 load priority");

        // R8 fast pacing
        test_fast = 1'b1;
        @(negedge clk);
        pulse1();
        snap_model("R8 slow tick ignored");
        for (int k = 0; k < 40; k++) begin
            pulse32(); m_step();
        end
        snap_model("R8 fast ticks");
        test_fast = 1'b0;
        pulse32();
        snap_model("R8 fast tick ignored in normal");

        // R9 parallel increment
        test_par = 1'b1;
        setm(59, 12, 23, 31, 12, 99, 7, 52);
        do_load(mpack());
        pulse1(); m_par();
        snap_cmp("R9 parallel wrap", 64'h00_01_00_01_01_00_13_00, 8'hFF);
        mfl = '0;
        test_fast = 1'b1;
        @(negedge clk);
        pulse1();
        snap_model("R9 R8 slow ignored");
        for (int k = 0; k < 70; k++) begin
            pulse32(); m_par();
        end
        snap_model("R9 fast parallel");
        test_fast = 1'b0;
        test_par = 1'b0;
        @(negedge clk);

        // R2 R3 R4 day-by-day sweep across years and week rolls
        setm(59, 59, 23, 20, 12, 3, 1, 51);
        do_load(mpack());
        for (int k = 0; k < 800; k++) begin
            m[0] = 59; m[1] = 59; m[2] = 23;
            do_load(mpack());
            pulse1(); m_step();
            snap_model("R2 R3 R4 day sweep");
        end

        // R2 continuous seconds run
        setm(0, 50, 22, 28, 2, 8, 6, 9);
        do_load(mpack());
        for (int k = 0; k < 6000; k++) begin
            pulse1(); m_step();
            if (k % 500 == 499) snap_model("R2 R7 continuous");
        end

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule